// File: doc/BRIEF.md
# RTC Sub-Second Increment Filter

This block turns a measured count of the low-frequency oscillator, taken over 32 of its periods against a fast reference, into the sub-second increment that a real-time counter adds on every tick. The calibration sequencer presents the count with a one-cycle valid strobe. The block scales the count by a fixed constant with a pipelined multiplier, smooths the result against the previous increment, and writes it out as a 16-bit low half and an upper half. An update request follows and stays high until the next calibration pass begins.

The first measurement after reset bypasses the smoothing, so the counter locks onto the right rate at once. Every later measurement is averaged with the value already in use. This halves the effect of a single noisy count.

Top module: `rtc_inc_filter`

## Requirements
- R1: After reset, `inc_lo`, `inc_hi`, `inc_wr`, `upd_req` and `busy` are all zero.
- R2: The raw increment is floor(result * 45813 / 256). For the first accepted measurement after reset, the output increment is the low 24 bits of this raw value.
- R3: For each later measurement, the output increment is the low 24 bits of floor((previous 24-bit increment + raw) / 2).
- R4: `inc_lo` carries bits 15:0 of the 24-bit increment and `inc_hi` carries bits 23:16. Both change only in the cycle in which `inc_wr` is high.
- R5: If `res_valid` is sampled high at clock edge E0 while idle, the new halves and a one-cycle `inc_wr` pulse appear after edge E0+3. `upd_req` rises after edge E0+4.
- R6: `upd_req` stays high until `pass_start` is sampled high. It is then low after that edge.
- R7: `busy` is high from the edge that accepts `res_valid` until the edge on which `upd_req` rises. A `res_valid` that arrives while `busy` is high is ignored and does not change the result.
- R8: A reset taken between measurements brings back the unfiltered first-measurement behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_start | input | 1 | Start of a calibration pass; clears the update request |
| res_valid | input | 1 | Measurement result strobe |
| res_data | input | RES_W | Period count over 32 low-frequency periods |
| inc_lo | output | LO_W | Low half of the increment |
| inc_hi | output | INC_W-LO_W | Upper half of the increment |
| inc_wr | output | 1 | One-cycle strobe when the halves are written |
| upd_req | output | 1 | Request to load the new increment |
| busy | output | 1 | Measurement in flight |

## Verification
The bench builds the block with its default values: a 24-bit result, a 24-bit increment split 16/8, the constant 45813 and a shift of 8. At these values the largest counts give raw values wider than 24 bits. This exercises the truncation of both the unfiltered first value and the filtered mean. The averaging is driven through sequences of rising and falling counts, a count of zero and the all-ones count. Between these, resets test the return to unfiltered mode. Strobes that land while busy, and pass starts, are timed against the update request.

// File: rtl/rtc_inc_filter.sv
module rtc_inc_filter #(
  parameter int RES_W = 24,
  parameter int INC_W = 24,
  parameter int LO_W  = 16,
  parameter int SCALE = 45813,
  parameter int SHIFT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pass_start,
  input  logic                  res_valid,
  input  logic [RES_W-1:0]      res_data,
  output logic [LO_W-1:0]       inc_lo,
  output logic [INC_W-LO_W-1:0] inc_hi,
  output logic                  inc_wr,
  output logic                  upd_req,
  output logic                  busy
);
  localparam int SC_W   = $clog2(SCALE + 1);
  localparam int HALF   = RES_W / 2;
  localparam int PLO_W  = HALF + SC_W;
  localparam int PHI_W  = RES_W - HALF + SC_W;
  localparam int PROD_W = RES_W + SC_W;
  localparam logic [SC_W-1:0] SC = SC_W'(SCALE);

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_SUM, S_AVG, S_UPD} st_t;
  st_t st;

  logic [RES_W-1:0]  res_q;
  logic [PLO_W-1:0]  pr_lo;
  logic [PHI_W-1:0]  pr_hi;
  logic [INC_W:0]    raw_q;
  logic [INC_W-1:0]  inc;
  logic              first;
  logic [PROD_W-1:0] psum;
  logic [INC_W-1:0]  nxt;

  assign psum = (PROD_W'(pr_hi) << HALF) + PROD_W'(pr_lo);
  assign nxt  = first ? raw_q[INC_W-1:0]
                      : INC_W'(({1'b0, inc} + raw_q) >> 1);
  assign busy   = (st != S_IDLE);
  assign inc_lo = inc[LO_W-1:0];
  assign inc_hi = inc[INC_W-1:LO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      res_q   <= '0;
      pr_lo   <= '0;
      pr_hi   <= '0;
      raw_q   <= '0;
      inc     <= '0;
      first   <= 1'b1;
      inc_wr  <= 1'b0;
      upd_req <= 1'b0;
    end else begin
      inc_wr <= 1'b0;
      if (pass_start) upd_req <= 1'b0;
      case (st)
        S_IDLE: if (res_valid) begin
          res_q <= res_data;
          st    <= S_MUL;
        end
        S_MUL: begin
          pr_lo <= PLO_W'(res_q[HALF-1:0]) * PLO_W'(SC);
          pr_hi <= PHI_W'(res_q[RES_W-1:HALF]) * PHI_W'(SC);
          st    <= S_SUM;
        end
        S_SUM: begin
          raw_q <= (INC_W+1)'(psum >> SHIFT);
          st    <= S_AVG;
        end
        S_AVG: begin
          inc    <= nxt;
          first  <= 1'b0;
          inc_wr <= 1'b1;
          st     <= S_UPD;
        end
        S_UPD: begin
          upd_req <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rtc_inc_filter_chk #(
  parameter int INC_W = 24,
  parameter int LO_W  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pass_start,
  input logic                  res_valid,
  input logic [LO_W-1:0]       inc_lo,
  input logic [INC_W-LO_W-1:0] inc_hi,
  input logic                  inc_wr,
  input logic                  upd_req,
  input logic                  busy
);
  // R4
  halves_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_wr |=> ($stable(inc_lo) && $stable(inc_hi)) || inc_wr);
  // R5
  upd_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_wr |=> upd_req);
  // R6
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start && !inc_wr |=> !upd_req);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !busy |=> busy);
  // R7
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_wr |-> busy);
  // R5
  upd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req) |-> !busy && $past(inc_wr));
endmodule

bind rtc_inc_filter rtc_inc_filter_chk #(.INC_W(INC_W), .LO_W(LO_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .res_valid(res_valid),
  .inc_lo(inc_lo), .inc_hi(inc_hi), .inc_wr(inc_wr), .upd_req(upd_req),
  .busy(busy));

// File: tb/test_rtc_inc_filter.sv
module test_rtc_inc_filter;
  logic clk = 0, rst_n = 0, pass_start = 0, res_valid = 0;
  logic [23:0] res_data = '0;
  logic [15:0] inc_lo;
  logic [7:0]  inc_hi;
  logic inc_wr, upd_req, busy;
  int total = 0, bad = 0;
  longint ref_prev = 0;
  bit ref_first = 1;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_inc_filter i_rtc_inc_filter (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .res_valid(res_valid),
    .res_data(res_data), .inc_lo(inc_lo), .inc_hi(inc_hi), .inc_wr(inc_wr),
    .upd_req(upd_req), .busy(busy));

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    ref_first = 1; ref_prev = 0;
  endtask

  function automatic longint model(longint r);
    longint raw = (r * 45813) >> 8;
    longint e = ref_first ? (raw & 24'hFFFFFF) : (((ref_prev + raw) >> 1) & 24'hFFFFFF);
    return e;
  endfunction

  task automatic measure(longint r, string req, bit poke_busy);
    longint e = model(r);
    @(negedge clk); res_valid = 1; res_data = 24'(r);
    @(negedge clk); res_valid = 0;
    chk("R7 busy after accept", longint'(busy), 1);
    if (poke_busy) begin res_valid = 1; res_data = 24'h123456; end
    @(negedge clk); res_valid = 0;
    @(negedge clk);
    chk("R5 no early write", longint'(inc_wr), 0);
    @(negedge clk);
    chk("R5 inc_wr pulse", longint'(inc_wr), 1);
    chk({req, " value"}, longint'({inc_hi, inc_lo}), e);
    chk("R4 low half", longint'(inc_lo), e & 16'hFFFF);
    chk("R4 high half", longint'(inc_hi), (e >> 16) & 8'hFF);
    @(negedge clk);
    chk("R5 upd_req rise", longint'(upd_req), 1);
    chk("R7 busy low", longint'(busy), 0);
    chk("R5 inc_wr one cycle", longint'(inc_wr), 0);
    ref_prev = e; ref_first = 0;
    @(negedge clk); pass_start = 1;
    @(negedge clk); pass_start = 0;
    chk("R6 upd_req cleared", longint'(upd_req), 0);
  endtask

  task automatic t_reset();
    chk("R1 inc", longint'({inc_hi, inc_lo}), 0);
    chk("R1 inc_wr", longint'(inc_wr), 0);
    chk("R1 upd_req", longint'(upd_req), 0);
    chk("R1 busy", longint'(busy), 0);
  endtask

  task automatic t_hold();
    measure(5000, "R2 first", 0);
    repeat (5) @(negedge clk);
    chk("R6 stays low", longint'(upd_req), 0);
    @(negedge clk); res_valid = 1; res_data = 24'd4900;
    @(negedge clk); res_valid = 0;
    repeat (4) @(negedge clk);
    ref_prev = model(4900); ref_first = 0;
    repeat (6) @(negedge clk);
    chk("R6 held without pass_start", longint'(upd_req), 1);
    chk("R4 halves stable", longint'({inc_hi, inc_lo}), ref_prev);
    @(negedge clk); pass_start = 1;
    @(negedge clk); pass_start = 0;
    chk("R6 cleared", longint'(upd_req), 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    measure(1000, "R2 first", 0);
    measure(1100, "R3 rising", 0);
    measure(900, "R3 falling", 0);
    measure(0, "R3 zero", 0);
    measure(24'hFFFFFF, "R3 max", 0);
    measure(1024, "R7 ignored strobe", 1);
    do_reset();
    t_reset();
    measure(24'hFFFFFF, "R8 first after reset trunc", 0);
    measure(12345, "R3 after max", 0);
    do_reset();
    measure(777, "R8 first unfiltered", 0);
    do_reset();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); total++; bad++;
        $display("FAIL watchdog act=timeout exp=done"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule